// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral on a simple 32-bit register bus. Software must keep refreshing it. If it does not, a 12-bit down-counter runs out and the block raises a reset request for the rest of the chip. The counter is clocked by a programmable divider. That divider advances on a tick-enable input, which stands in for a slow, always-on oscillator.

Software controls the block only through 16-bit magic values written to a key register:
- One value opens the divider and reload registers for writing.
- One value starts the watchdog. Once started, nothing but a system reset stops it.
- One value refreshes the counter.

A new divider or reload value does not take effect at once. It moves into the counting logic a fixed number of ticks later. Until then, a per-register pending flag stays visible in a status register.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the divider register reads 0, the reload register reads 0xFFF and the status register reads 0. `resetReq` is low and the watchdog is stopped.
- R2: Register selection uses `busAddr[3:2]`: key at 0x0, divider at 0x4, reload at 0x8, status at 0xC. Read data follows `busAddr` combinationally. The key register always reads 0.
- R3: A key write whose low 16 bits are 0x5555 opens write access. While access is closed, writes to the divider (`busWdata[2:0]`) and reload (`busWdata[11:0]`) registers are ignored and set no status flag.
- R4: Any key write whose low 16 bits are not 0x5555 closes write access again.
- R5: Key 0xCCCC starts the watchdog. It loads the counter from the active reload value and clears the divider. No later write stops the watchdog.
- R6: Key 0xAAAA reloads the counter from the active reload value and clears the divider. A refresh that lands in the same cycle as an expiry suppresses that expiry.
- R7: Divider code c selects a tick division of 4·2^c for c = 0..5. Codes 6 and 7 both select 256.
- R8: Let D be the division and N the active reload value. With ticks on every cycle, `resetReq` is high for exactly one cycle, D·(N+1) cycles after a start or refresh. The counter then reloads, so the next pulse comes D·(N+1) cycles later.
- R9: An accepted divider or reload write sets status bit 0 or bit 1 respectively. That bit clears on the third tick after the write, when the new value becomes active. A further accepted write to the same register restarts the wait.
- R10: While `tickEn` is low, the divider, the counter and the pending-flag waits do not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | Write when high, with busSel |
| busAddr | input | 4 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| tickEn | input | 1 | Slow-clock tick enable |
| resetReq | output | 1 | One-cycle reset request on expiry |

## Verification
The assertions check the following on every cycle:
- the reset pulse is one cycle wide and only occurs once the watchdog runs;
- the running state is sticky;
- non-unlock keys close write access;
- locked writes never raise a pending flag;
- accepted writes always raise one;
- flags hold while no tick arrives;
- a refresh suppresses any expiry in its cycle.

Only the bench scenarios show the following:
- the exact expiry period for each divider code and reload value;
- the periodic repetition after an expiry;
- that regular refreshes keep the request quiet;
- the tick on which a pending flag clears, and the restart of that wait;
- that ignored writes really leave the register contents unchanged.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int KEY_W = 16;
  localparam int PRE_W = 3;
  localparam int RLD_W = 12;
  localparam int DIV_W = 8;
  localparam int DIV_MIN_LOG2 = 2;
  localparam int NUM_CHAN = 2;

  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;

  localparam logic [1:0] IDX_KEY = 2'd0;
  localparam logic [1:0] IDX_PRE = 2'd1;
  localparam logic [1:0] IDX_RLD = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  localparam int CH_PRE = 0;
  localparam int CH_RLD = 1;

  typedef struct packed {
    logic start;
    logic refresh;
    logic applyPre;
    logic applyRld;
    logic [PRE_W-1:0] preCode;
    logic [RLD_W-1:0] rldVal;
  } kwdtStrobe_t;

  // terminal count of the tick divider for a given code
  function automatic logic [DIV_W-1:0] divMaxOf(input logic [PRE_W-1:0] code);
    int lg;
    lg = int'(code) + DIV_MIN_LOG2;
    if (lg > DIV_W) lg = DIV_W;
    return DIV_W'((1 << lg) - 1);
  endfunction
endpackage

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int SYNC_TICKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic busSel,
  input  logic busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic tickEn,
  output logic unlocked,
  output logic [NUM_CHAN-1:0] pendFlags,
  output kwdtStrobe_t strobe
);
  localparam int SYNC_W = $clog2(SYNC_TICKS + 1);
  localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(SYNC_TICKS - 1);

  logic [1:0] regIdx;
  logic wrAny, wrKey, wrPre, wrRld;
  logic [KEY_W-1:0] keyVal;
  logic [PRE_W-1:0] preShadow;
  logic [RLD_W-1:0] rldShadow;
  logic [NUM_CHAN-1:0] chanWrite;
  logic [NUM_CHAN-1:0] chanApply;

  assign regIdx = busAddr[3:2];
  assign wrAny = busSel && busWe;
  assign wrKey = wrAny && (regIdx == IDX_KEY);
  assign wrPre = wrAny && (regIdx == IDX_PRE);
  assign wrRld = wrAny && (regIdx == IDX_RLD);
  assign keyVal = busWdata[KEY_W-1:0];

  assign chanWrite[CH_PRE] = wrPre && unlocked;
  assign chanWrite[CH_RLD] = wrRld && unlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      preShadow <= '0;
      rldShadow <= '1;
    end else begin
      if (wrKey) unlocked <= (keyVal == KEY_UNLOCK);
      if (chanWrite[CH_PRE]) preShadow <= busWdata[PRE_W-1:0];
      if (chanWrite[CH_RLD]) rldShadow <= busWdata[RLD_W-1:0];
    end
  end

  // one transfer channel per configuration register
  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    logic pend;
    logic [SYNC_W-1:0] waitCnt;
    logic lastTick;

    assign lastTick = pend && tickEn && (waitCnt == SYNC_LAST);
    assign chanApply[ch] = lastTick && !chanWrite[ch];
    assign pendFlags[ch] = pend;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pend <= 1'b0;
        waitCnt <= '0;
      end else if (chanWrite[ch]) begin
        pend <= 1'b1;
        waitCnt <= '0;
      end else if (pend && tickEn) begin
        if (waitCnt == SYNC_LAST) begin
          pend <= 1'b0;
          waitCnt <= '0;
        end else begin
          waitCnt <= waitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe = '0;
    strobe.start = wrKey && (keyVal == KEY_START);
    strobe.refresh = wrKey && (keyVal == KEY_REFRESH);
    strobe.applyPre = chanApply[CH_PRE];
    strobe.applyRld = chanApply[CH_RLD];
    strobe.preCode = preShadow;
    strobe.rldVal = rldShadow;
  end

  always_comb begin
    busRdata = '0;
    case (regIdx)
      IDX_PRE: busRdata[PRE_W-1:0] = preShadow;
      IDX_RLD: busRdata[RLD_W-1:0] = rldShadow;
      IDX_STAT: busRdata[NUM_CHAN-1:0] = pendFlags;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_datapath.sv
module kwdt_datapath
  import kwdt_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  kwdtStrobe_t strobe,
  output logic running,
  output logic resetReq
);
  logic [PRE_W-1:0] activePre;
  logic [RLD_W-1:0] activeRld;
  logic [DIV_W-1:0] preCnt;
  logic [RLD_W-1:0] wdCnt;
  logic divLast;
  logic expire;

  assign divLast = (preCnt >= divMaxOf(activePre));
  assign expire = running && tickEn && divLast && (wdCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePre <= '0;
      activeRld <= '1;
    end else begin
      if (strobe.applyPre) activePre <= strobe.preCode;
      if (strobe.applyRld) activeRld <= strobe.rldVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      preCnt <= '0;
      wdCnt <= '1;
      resetReq <= 1'b0;
    end else begin
      resetReq <= expire && !strobe.start && !strobe.refresh;
      if (strobe.start || strobe.refresh) begin
        if (strobe.start) running <= 1'b1;
        preCnt <= '0;
        wdCnt <= activeRld;
      end else if (running && tickEn) begin
        if (divLast) begin
          preCnt <= '0;
          wdCnt <= (wdCnt == '0) ? activeRld : wdCnt - 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int SYNC_TICKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic busSel,
  input  logic busWe,
  input  logic [3:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic tickEn,
  output logic resetReq
);
  kwdtStrobe_t strobe;
  logic unlocked;
  logic running;
  logic [NUM_CHAN-1:0] pendFlags;

  kwdt_ctrl #(.SYNC_TICKS(SYNC_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickEn(tickEn), .unlocked(unlocked), .pendFlags(pendFlags),
    .strobe(strobe)
  );

  kwdt_datapath dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .running(running), .resetReq(resetReq)
  );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker (
  input logic clk,
  input logic rstN,
  input logic busSel,
  input logic busWe,
  input logic [3:0] busAddr,
  input logic [31:0] busWdata,
  input logic tickEn,
  input logic resetReq,
  input logic running,
  input logic unlocked,
  input logic [1:0] pendFlags
);
  logic wrAny, wrKey, wrRld;
  assign wrAny = busSel && busWe;
  assign wrKey = wrAny && (busAddr[3:2] == 2'd0);
  assign wrRld = wrAny && (busAddr[3:2] == 2'd2);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  assert_req_needs_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> running);
  assert_run_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running);
  assert_start_runs_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrKey && busWdata[15:0] == 16'hCCCC) |=> running);
  assert_relock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrKey && busWdata[15:0] != 16'h5555) |=> !unlocked);
  assert_locked_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrRld && !unlocked && !pendFlags[1]) |=> !pendFlags[1]);
  assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrRld && unlocked) |=> pendFlags[1]);
  assert_tick_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrAny) |=> $stable(pendFlags));
  assert_refresh_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrKey && busWdata[15:0] == 16'hAAAA) |=> !resetReq);
endmodule

bind kwdt_top kwdt_checker chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .tickEn(tickEn),
  .resetReq(resetReq), .running(running), .unlocked(unlocked),
  .pendFlags(pendFlags)
);

// File: tb/kwdt_top_tb_top.sv
`timescale 1ns/1ps
module kwdt_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0;
  logic busWe = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic tickEn = 1'b1;
  logic resetReq;
  int nChecks = 0;
  int nFails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  kwdt_top dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickEn(tickEn), .resetReq(resetReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles from now until resetReq is seen high, 0 if limit hit
  task automatic waitPulse(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (resetReq) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic waitPendClear();
    logic [31:0] s;
    for (int i = 0; i < 50; i++) begin
      busRead(4'hC, s);
      if (s[1:0] == 2'b00) break;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(4'h4, d); check("R1 divider", d, 32'h0);
    busRead(4'h8, d); check("R1 reload", d, 32'hFFF);
    busRead(4'hC, d); check("R1 status", d, 32'h0);
    busRead(4'h0, d); check("R2 key reads zero", d, 32'h0);
    check("R1 resetReq", {31'b0, resetReq}, 32'h0);
  endtask

  task automatic testLocked();
    logic [31:0] d;
    busWrite(4'h8, 32'h5);
    busRead(4'hC, d); check("R3 no flag when locked", d, 32'h0);
    busWrite(4'h4, 32'h3);
    idle(5);
    busRead(4'h8, d); check("R3 locked reload ignored", d, 32'hFFF);
    busRead(4'h4, d); check("R3 locked divider ignored", d, 32'h0);
  endtask

  task automatic testPending();
    logic [31:0] d;
    busWrite(4'h0, 32'h5555);
    busWrite(4'h8, 32'h5);
    busRead(4'hC, d); check("R9 reload flag set", d, 32'h2);
    idle(2);
    busRead(4'hC, d); check("R9 reload flag held", d, 32'h2);
    idle(1);
    busRead(4'hC, d); check("R9 reload flag clears", d, 32'h0);
    busRead(4'h8, d); check("R2 reload readback", d, 32'h5);
    busWrite(4'h4, 32'h1);
    idle(2);
    busWrite(4'h4, 32'h0);
    idle(2);
    busRead(4'hC, d); check("R9 restarted wait held", d, 32'h1);
    idle(1);
    busRead(4'hC, d); check("R9 restarted wait clears", d, 32'h0);
  endtask

  task automatic testRelock();
    logic [31:0] d;
    busWrite(4'h0, 32'h1234);
    busWrite(4'h8, 32'h9);
    busRead(4'h8, d); check("R4 relocked write ignored", d, 32'h5);
    busWrite(4'h0, 32'hFFFF5555);
    busWrite(4'h8, 32'h3);
    busRead(4'h8, d); check("R3 low-half key unlocks", d, 32'h3);
    busWrite(4'h0, 32'h0);
    busWrite(4'h8, 32'h7);
    busRead(4'h8, d); check("R4 zero key relocks", d, 32'h3);
  endtask

  task automatic testFreeze();
    logic [31:0] d;
    busWrite(4'h0, 32'h5555);
    tickEn = 1'b0;
    busWrite(4'h8, 32'h3);
    idle(20);
    busRead(4'hC, d); check("R10 flag frozen", d, 32'h2);
    tickEn = 1'b1;
    idle(3);
    busRead(4'hC, d); check("R10 flag resumes", d, 32'h0);
    busWrite(4'h0, 32'h0);
  endtask

  task automatic testStart();
    int n;
    check("R5 idle no request", {31'b0, resetReq}, 32'h0);
    busWrite(4'h0, 32'hCCCC);
    waitPulse(200, n); check("R8 first period d4 n3", n, 16);
    @(negedge clk);
    check("R8 pulse one cycle", {31'b0, resetReq}, 32'h0);
    waitPulse(200, n); check("R8 repeat period", n, 15);
    busWrite(4'h0, 32'h0);
    busWrite(4'h0, 32'h1234);
    waitPulse(40, n); check("R5 keeps running", {31'b0, n != 0}, 32'h1);
  endtask

  task automatic testRefresh();
    int seen;
    int n;
    seen = 0;
    busWrite(4'h0, 32'hAAAA);
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (resetReq) seen++;
      end
      busWrite(4'h0, 32'hAAAA);
      if (resetReq) seen++;
    end
    check("R6 refresh holds off", seen, 0);
    waitPulse(200, n); check("R6 period after refresh", n, 16);
  endtask

  task automatic divCase(input int code, input int rld, input int expN);
    int n;
    busWrite(4'h0, 32'h5555);
    busWrite(4'h4, code);
    busWrite(4'h8, rld);
    waitPendClear();
    busWrite(4'h0, 32'h0);
    busWrite(4'h0, 32'hAAAA);
    waitPulse(5000, n);
    check($sformatf("R7 code %0d reload %0d", code, rld), n, expN);
  endtask

  task automatic testDividers();
    divCase(1, 0, 8);
    divCase(2, 3, 64);
    divCase(5, 1, 256);
    divCase(6, 1, 512);
    divCase(7, 1, 512);
    divCase(0, 0, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLocked();
    testPending();
    testRelock();
    testFreeze();
    testStart();
    testRefresh();
    testDividers();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule